// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block changes the system clock mode without losing the contents of external SDRAM. A one-cycle start pulse arrives with a 4-bit target mode. The block then works through a fixed order of register accesses on a simple request/acknowledge master port. It puts the SDRAM controller into self-refresh and waits for the controller to confirm it. It programs the clock controller and waits a settling window. It then takes the SDRAM out of self-refresh, waits for that to be confirmed, and reports completion.

Every step begins only after the previous access has been acknowledged, so the port has at most one access outstanding at any time. Both status polling loops have a bounded number of attempts. If a loop runs out of attempts, the block stops with a sticky error flag. When the failure happens on the entry side, the block first tries to release self-refresh.

Top module: `clk_mode_seq`

## Requirements
- R1: At most one access is outstanding. While `req_o` is high and `ack_i` is low, `we_o`, `addr_o` and `wdata_o` hold their values. An access completes in the cycle where both `req_o` and `ack_i` are high.
- R2: After reset the block is idle with `busy_o`, `done_o`, `err_o` and `req_o` low. A start accepted while idle raises `busy_o`. A start pulse while `busy_o` is high is ignored, and its mode value never reaches the bus.
- R3: The first access reads the clock control word at CKC_BASE+0x00. The second access writes 1 to the SDRAM refresh control register at SDC_BASE+0x30. Bit 0 of that register is the self-refresh request.
- R4: The block reads the SDRAM status register at SDC_BASE+0x28 until bit 0 reads 1, which means self-refresh is active. No clock controller write happens before that read.
- R5: The next access writes the target mode to CKC_BASE+0x08. The mode sits in bits 27:24 and all other bits are 0. The mode used is the one captured with the accepted start.
- R6: The next access writes CKC_BASE+0x00 with the control word captured by the first read, with only bit 31 (switch enable) forced to 1.
- R7: After the enable write completes, the block makes no bus request for at least SETTLE_CYCLES (default 256) cycles and for at most SETTLE_CYCLES+4 cycles.
- R8: The block then writes 0 to SDC_BASE+0x30 and reads SDC_BASE+0x28 until bit 0 reads 0.
- R9: When the read showing bit 0 = 0 completes, `done_o` is high for exactly one cycle while `err_o` is low. `busy_o` is low in the following cycle.
- R10: If POLL_LIMIT consecutive entry status reads all return bit 0 = 0, the block writes 0 to SDC_BASE+0x30, sets `err_o`, drops `busy_o` and never pulses `done_o`.
- R11: If POLL_LIMIT consecutive exit status reads all return bit 0 = 1, the block sets `err_o`, drops `busy_o`, does not pulse `done_o` and makes no further access.
- R12: `err_o` stays high until the next start is accepted. Accepting that start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 4 | Target clock mode, captured on accepted start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky polling timeout flag |
| req_o | output | 1 | Bus access request |
| we_o | output | 1 | Access is a write |
| addr_o | output | 32 | Access byte address |
| wdata_o | output | 32 | Write data |
| ack_i | input | 1 | Access acknowledge |
| rdata_i | input | 32 | Read data, valid with `ack_i` |

## Verification
The hardest conditions to reach from the ports are the two timeout exits. They need a controller that never confirms self-refresh, or never leaves it. The bench's responder model lets each run choose how many status reads return the old value. Setting that count beyond the attempt limit produces each timeout on demand. Setting it to one below the limit exercises the last allowed attempt. A stray start pulse with a different mode is also injected in the middle of a sequence, and the scoreboard confirms that the mode written is unchanged.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_SR_ON, S_POLL_ON, S_WR_MODE, S_WR_EN,
    S_SETTLE, S_SR_OFF, S_POLL_OFF, S_DONE, S_ABORT
  } cms_state_e;

  localparam logic [11:0] OFS_CTL    = 12'h000;
  localparam logic [11:0] OFS_SWMODE = 12'h008;
  localparam logic [11:0] OFS_STAT   = 12'h028;
  localparam logic [11:0] OFS_REFCTL = 12'h030;
  localparam int MODE_LSB = 24;
  localparam int EN_BIT   = 31;
endpackage

// File: rtl/cms_down_cnt.sv
module cms_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = load_i ? load_val_i : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cms_bus_port.sv
module cms_bus_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i
);
  logic req_q, we_q, rsp_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdat_q;
  logic fire;

  assign fire = req_q & ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= fire;
      if (issue_i)   req_q <= 1'b1;
      else if (fire) req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (issue_i) begin
      we_q    <= cmd_we_i;
      addr_q  <= cmd_addr_i;
      wdata_q <= cmd_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdat_q <= '0;
    else if (fire) rdat_q <= rdata_i;
  end

  assign req_o      = req_q;
  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign rsp_o      = rsp_q;
  assign rsp_data_o = rdat_q;
endmodule

// File: rtl/cms_fsm.sv
module cms_fsm
  import cms_pkg::*;
#(
  parameter int             AW       = 32,
  parameter int             DW       = 32,
  parameter int             MW       = 4,
  parameter logic [AW-1:0]  SDC_BASE = '0,
  parameter logic [AW-1:0]  CKC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  input  logic          rsp_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          issue_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o,
  output logic          s_load_o,
  output logic          s_dec_o,
  input  logic          s_zero_i,
  output logic          p_load_o,
  output logic          p_dec_o,
  input  logic          p_zero_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [AW-1:0] A_CTL    = CKC_BASE + AW'(OFS_CTL);
  localparam logic [AW-1:0] A_SWMODE = CKC_BASE + AW'(OFS_SWMODE);
  localparam logic [AW-1:0] A_STAT   = SDC_BASE + AW'(OFS_STAT);
  localparam logic [AW-1:0] A_REFCTL = SDC_BASE + AW'(OFS_REFCTL);
  localparam logic [DW-1:0] EN_MASK  = DW'(1) << EN_BIT;

  cms_state_e st_q, st_d;
  logic          pend_q, pend_d;
  logic          err_q, err_d;
  logic [MW-1:0] mode_q;
  logic [DW-1:0] ctl_q;
  logic          acc, mode_en, ctl_en, set_err, clr_err;

  always_comb begin
    st_d        = st_q;
    acc         = 1'b0;
    cmd_we_o    = 1'b0;
    cmd_addr_o  = '0;
    cmd_wdata_o = '0;
    mode_en     = 1'b0;
    ctl_en      = 1'b0;
    set_err     = 1'b0;
    clr_err     = 1'b0;
    s_load_o    = 1'b0;
    s_dec_o     = 1'b0;
    p_load_o    = 1'b0;
    p_dec_o     = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d    = S_RD_CTL;
        mode_en = 1'b1;
        clr_err = 1'b1;
      end
      S_RD_CTL: begin
        acc = 1'b1; cmd_addr_o = A_CTL;
        if (rsp_i) begin ctl_en = 1'b1; st_d = S_SR_ON; end
      end
      S_SR_ON: begin
        acc = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = A_REFCTL; cmd_wdata_o = DW'(1);
        if (rsp_i) begin st_d = S_POLL_ON; p_load_o = 1'b1; end
      end
      S_POLL_ON: begin
        acc = 1'b1; cmd_addr_o = A_STAT;
        if (rsp_i) begin
          if (rsp_data_i[0])  st_d = S_WR_MODE;
          else if (p_zero_i) begin st_d = S_ABORT; set_err = 1'b1; end
          else                p_dec_o = 1'b1;
        end
      end
      S_WR_MODE: begin
        acc = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = A_SWMODE;
        cmd_wdata_o = DW'(mode_q) << MODE_LSB;
        if (rsp_i) st_d = S_WR_EN;
      end
      S_WR_EN: begin
        acc = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = A_CTL;
        cmd_wdata_o = ctl_q | EN_MASK;
        if (rsp_i) begin st_d = S_SETTLE; s_load_o = 1'b1; end
      end
      S_SETTLE: begin
        if (s_zero_i) st_d = S_SR_OFF;
        else          s_dec_o = 1'b1;
      end
      S_SR_OFF: begin
        acc = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = A_REFCTL;
        if (rsp_i) begin st_d = S_POLL_OFF; p_load_o = 1'b1; end
      end
      S_POLL_OFF: begin
        acc = 1'b1; cmd_addr_o = A_STAT;
        if (rsp_i) begin
          if (!rsp_data_i[0]) st_d = S_DONE;
          else if (p_zero_i)  begin st_d = S_IDLE; set_err = 1'b1; end
          else                p_dec_o = 1'b1;
        end
      end
      S_DONE: st_d = S_IDLE;
      S_ABORT: begin
        acc = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = A_REFCTL;
        if (rsp_i) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    issue_o = acc & ~pend_q;
    pend_d  = issue_o ? 1'b1 : (rsp_i ? 1'b0 : pend_q);
    err_d   = clr_err ? 1'b0 : (set_err ? 1'b1 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= rsp_data_i;
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);
  assign err_o  = err_q;
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq #(
  parameter int            AW            = 32,
  parameter int            DW            = 32,
  parameter int            MW            = 4,
  parameter int            SETTLE_CYCLES = 256,
  parameter int            POLL_LIMIT    = 16,
  parameter logic [AW-1:0] SDC_BASE      = 32'h4000_0000,
  parameter logic [AW-1:0] CKC_BASE      = 32'h4000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic          issue, cmd_we, rsp;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rsp_data;
  logic          s_load, s_dec, s_zero, p_load, p_dec, p_zero;

  cms_fsm #(
    .AW(AW), .DW(DW), .MW(MW), .SDC_BASE(SDC_BASE), .CKC_BASE(CKC_BASE)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .rsp_i(rsp), .rsp_data_i(rsp_data),
    .issue_o(issue), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr), .cmd_wdata_o(cmd_wdata),
    .s_load_o(s_load), .s_dec_o(s_dec), .s_zero_i(s_zero),
    .p_load_o(p_load), .p_dec_o(p_dec), .p_zero_i(p_zero),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  cms_bus_port #(.AW(AW), .DW(DW)) bus_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .cmd_we_i(cmd_we),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_o(rsp), .rsp_data_o(rsp_data),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .ack_i(ack_i), .rdata_i(rdata_i)
  );

  cms_down_cnt #(.W(SW)) settle_cnt_i (
    .clk(clk), .rst_n(rst_n), .load_i(s_load),
    .load_val_i(SW'(SETTLE_CYCLES - 1)), .dec_i(s_dec), .zero_o(s_zero)
  );

  cms_down_cnt #(.W(PW)) poll_cnt_i (
    .clk(clk), .rst_n(rst_n), .load_i(p_load),
    .load_val_i(PW'(POLL_LIMIT - 1)), .dec_i(p_dec), .zero_o(p_zero)
  );
endmodule

// File: rtl/cms_chk.sv
module cms_chk #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] SDC_BASE = '0,
  parameter logic [AW-1:0] CKC_BASE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          req_o,
  input logic          we_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] wdata_o,
  input logic          ack_i,
  input logic          sr_bit_i
);
  localparam logic [AW-1:0] A_CTL    = CKC_BASE;
  localparam logic [AW-1:0] A_SWMODE = CKC_BASE + AW'(8);
  localparam logic [AW-1:0] A_STAT   = SDC_BASE + AW'(32'h28);
  localparam logic [AW-1:0] A_REFCTL = SDC_BASE + AW'(32'h30);

  logic sr_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_ok_q <= 1'b0;
    else if (req_o && ack_i && !we_o && addr_o == A_STAT) sr_ok_q <= sr_bit_i;
    else if (req_o && ack_i && we_o && addr_o == A_REFCTL) sr_ok_q <= 1'b0;
  end

  a_r1_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));

  a_r4_switch_after_sr: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && we_o && (addr_o == A_SWMODE || addr_o == A_CTL) |-> sr_ok_q);

  a_r5_mode_field: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && we_o && addr_o == A_SWMODE |-> (wdata_o & ~(DW'(4'hF) << 24)) == '0);

  a_r6_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && we_o && addr_o == A_CTL |-> wdata_o[31]);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  a_r9_done_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !err_o);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start_i |=> err_o);
endmodule

bind clk_mode_seq cms_chk #(
  .AW(AW), .DW(DW), .SDC_BASE(SDC_BASE), .CKC_BASE(CKC_BASE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .req_o(req_o), .we_o(we_o),
  .addr_o(addr_o), .wdata_o(wdata_o), .ack_i(ack_i), .sr_bit_i(rdata_i[0])
);

// File: tb/clk_mode_seq_tb.sv
module clk_mode_seq_tb_top;
  localparam logic [31:0] SDC = 32'h4000_0000;
  localparam logic [31:0] CKC = 32'h4000_1000;
  localparam int PL = 16;
  localparam int ST = 256;
  localparam int ACK_DLY = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [3:0] mode_i;
  logic busy_o, done_o, err_o, req_o, we_o, ack_i;
  logic [31:0] addr_o, wdata_o, rdata_i;

  always #5 clk = ~clk;

  clk_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .ack_i(ack_i), .rdata_i(rdata_i)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } xact_t;
  xact_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // responder model state
  logic [31:0] ctl_reg;
  bit sr_tgt;
  int sr_lag, kin, kout, wcnt, done_cnt, gap;
  bit gap_on;
  bit          h_we;
  logic [31:0] h_addr, h_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      ack_i = 1'b0; rdata_i = '0; wcnt = 0; gap_on = 0;
    end else begin
      if (done_o) done_cnt++;
      if (gap_on) begin
        if (req_o) begin
          check(gap >= ST && gap <= ST + 4, "R7", "settle gap", gap, ST);
          gap_on = 0;
        end else gap++;
      end
      if (ack_i) begin
        ack_i = 1'b0; wcnt = 0;
      end else if (req_o) begin
        if (wcnt == 0) begin
          h_we = we_o; h_addr = addr_o; h_data = wdata_o;
        end else begin
          check(we_o == h_we && addr_o == h_addr && wdata_o == h_data,
                "R1", "fields held while waiting", addr_o, h_addr);
        end
        if (wcnt < ACK_DLY) wcnt++;
        else begin
          xact_t e;
          ack_i = 1'b1;
          rdata_i = '0;
          if (exp_q.size() == 0) begin
            check(0, "R2", "unexpected access", addr_o, '0);
          end else begin
            e = exp_q.pop_front();
            check(we_o == e.we && addr_o == e.addr, e.tag, "access addr/dir", addr_o, e.addr);
            if (e.we) check(wdata_o == e.data, e.tag, "write data", wdata_o, e.data);
          end
          if (!we_o && addr_o == CKC) rdata_i = ctl_reg;
          if (!we_o && addr_o == SDC + 32'h28) begin
            if (sr_lag > 0) begin rdata_i = {31'b0, ~sr_tgt}; sr_lag--; end
            else rdata_i = {31'b0, sr_tgt};
          end
          if (we_o && addr_o == CKC) begin
            ctl_reg = wdata_o & 32'h7FFF_FFFF;
            gap_on = 1; gap = 0;
          end
          if (we_o && addr_o == SDC + 32'h30) begin
            sr_tgt = wdata_o[0];
            sr_lag = sr_tgt ? kin : kout;
          end
        end
      end
    end
  end

  task automatic push(bit we, logic [31:0] a, logic [31:0] d, string tag);
    xact_t e;
    e.we = we; e.addr = a; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // kind: 0 normal, 1 entry timeout, 2 exit timeout
  task automatic run(logic [3:0] m, logic [31:0] ctl, int ki, int ko, int kind, bit poke);
    ctl_reg = ctl; kin = ki; kout = ko; done_cnt = 0;
    push(0, CKC, '0, "R3");
    push(1, SDC + 32'h30, 32'h1, "R3");
    if (kind == 1) begin
      for (int i = 0; i < PL; i++) push(0, SDC + 32'h28, '0, "R10");
      push(1, SDC + 32'h30, 32'h0, "R10");
    end else begin
      for (int i = 0; i <= ki; i++) push(0, SDC + 32'h28, '0, "R4");
      push(1, CKC + 32'h8, {4'h0, m, 24'h0}, "R5");
      push(1, CKC, ctl | 32'h8000_0000, "R6");
      push(1, SDC + 32'h30, 32'h0, "R8");
      if (kind == 2) for (int i = 0; i < PL; i++) push(0, SDC + 32'h28, '0, "R11");
      else           for (int i = 0; i <= ko; i++) push(0, SDC + 32'h28, '0, "R8");
    end
    @(negedge clk); mode_i = m; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; mode_i = ~m;
    check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    check(err_o == 1'b0, "R12", "err cleared by start", err_o, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      mode_i = 4'hA; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
    check(busy_o == 1'b0, "R9", "busy low at end", busy_o, 0);
    check(exp_q.size() == 0, "R8", "all expected accesses seen", exp_q.size(), 0);
    if (kind == 0) begin
      check(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
      check(err_o == 1'b0, "R9", "no error", err_o, 0);
    end else begin
      check(done_cnt == 0, kind == 1 ? "R10" : "R11", "no done on timeout", done_cnt, 0);
      check(err_o == 1'b1, kind == 1 ? "R10" : "R11", "err set", err_o, 1);
    end
    repeat (8) @(negedge clk);
    check(req_o == 1'b0, "R11", "bus quiet after end", req_o, 0);
    check(err_o == (kind != 0), "R12", "err holds while idle", err_o, kind != 0);
    exp_q.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0;
    ctl_reg = '0; sr_tgt = 0; sr_lag = 0; kin = 0; kout = 0; done_cnt = 0;
    repeat (4) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && err_o == 0 && req_o == 0, "R2", "reset state",
          {busy_o, done_o, err_o, req_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(4'h5, 32'h0000_1234, 0, 0, 0, 0);
    run(4'hF, 32'h00AB_00CD, 3, 2, 0, 1);          // R2 stray start ignored
    run(4'h0, 32'h7FFF_FFFF, PL - 1, PL - 1, 0, 0); // last allowed attempt
    run(4'h9, 32'h0000_0001, 1000, 0, 1, 0);       // R10 entry timeout
    run(4'h3, 32'h1111_0000, 1, 1, 0, 0);          // R12 recover
    run(4'h6, 32'h0F0F_0F0F, 0, 1000, 2, 0);       // R11 exit timeout
    run(4'hC, 32'h0000_0000, 2, 0, 0, 0);
    summary();
  end
endmodule